// File: doc/BRIEF.md
# Row-Column Parallel Matrix Access Scheduler

This block drives the shared matrix store of an iterative product-code decoder in which one soft-in soft-out component decoder works on rows while a second works on columns of the same n-by-n matrix, at the same time. It produces every read and write-back address for a channel-value memory and an extrinsic-value memory. Both memories have two ports: port A belongs to the row decoder and port B to the column decoder. The extrinsic memory is updated in place. A value that one decoder writes back is read by the other decoder later in the same iteration, so no reconstruction buffer is needed between the row pass and the column pass.

Within a codeword the row decoder steps through symbol positions in ascending order. The column decoder steps through the mirrored positions in descending order, so the two ports never address the same cell in one cycle. A start pulse loads the number of iterations. Each iteration issues n*n read cycles, one codeword after another, and then waits a drain of L cycles so that the last write-backs complete, where L is the decoder latency. A one-cycle done pulse follows the final write-back. With L equal to n, a run of k iterations takes k*(n*n+n) cycles.

Top module: `btc_rc_sched`

## Requirements
- R1: While reset is applied and just after it, busy, done, cw_done, iter_done, clash and all four enables are low.
- R2: A symbol address is row*n+column, with the row index in the upper log2(n) bits. During iteration reads, port A addresses row c column i at read cycle c*n+i. It takes c from 0 to n-1 and, inside each codeword, i from 0 to n-1, one symbol per cycle with no gaps.
- R3: In the same cycle, port B reads row n-1-i of column c. This is the descending mirror of the port A position.
- R4: The two ports never present the same read address in one cycle, nor the same write address in one cycle. The clash output stays low.
- R5: Each read on a port is followed, exactly L cycles later, by a write-back enable on that same port to the same address.
- R6: Each iteration consists of n*n contiguous read cycles followed by L drain cycles with no reads. The next iteration's reads begin immediately after the drain.
- R7: Counting the first cycle after the start edge as cycle 0, busy is high for cycles 0 to K*(n*n+L)-1, and done is high only in cycle K*(n*n+L), for exactly one cycle.
- R8: cw_done is high exactly in the cycles where the write-back of position n-1 of a codeword is issued. iter_done is high exactly with the write-back of the last symbol of an iteration. While busy, iter_num gives the 0-based index of the current iteration.
- R9: A start pulse while busy has no effect on any output.
- R10: A start with K=0 makes no access and gives done in cycle 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start pulse, sampled when idle |
| iter_k | input | KW | Number of iterations to run |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle completion pulse |
| iter_num | output | KW | Current iteration index |
| a_rd_en | output | 1 | Port A (row) read enable |
| a_rd_addr | output | 2*HW | Port A read address |
| a_wr_en | output | 1 | Port A write-back enable |
| a_wr_addr | output | 2*HW | Port A write-back address |
| b_rd_en | output | 1 | Port B (column) read enable |
| b_rd_addr | output | 2*HW | Port B read address |
| b_wr_en | output | 1 | Port B write-back enable |
| b_wr_addr | output | 2*HW | Port B write-back address |
| cw_done | output | 1 | Last write-back of a codeword pair |
| iter_done | output | 1 | Last write-back of an iteration |
| clash | output | 1 | Same-address access on both ports |

## Verification
The checker assumes start is not raised in the cycle in which done is high, because an immediate zero-iteration restart would legally produce two back-to-back done pulses. The bench always leaves at least one idle cycle after done before the next start. Its random runs draw iteration counts of one to three, so every run fits inside the iteration-count width. Starts issued while busy carry a different iteration count, so any effect they had would appear in the address sequence.

// File: rtl/rcs_pkg.sv
package rcs_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_DRAIN = 2'd2
  } rcs_state_e;
endpackage

// File: rtl/rcs_addr_gen.sv
// Maps the linear read counter onto the two decoders' matrix positions.
module rcs_addr_gen #(
  parameter int HW = 3
) (
  input  logic [2*HW-1:0] sym,
  output logic [2*HW-1:0] row_addr,
  output logic [2*HW-1:0] col_addr,
  output logic            last_pos,
  output logic            last_sym
);
  logic [HW-1:0] cw;
  logic [HW-1:0] pos;

  always_comb begin
    cw       = sym[2*HW-1:HW];
    pos      = sym[HW-1:0];
    // row decoder: row cw, ascending column
    row_addr = {cw, pos};
    // column decoder: column cw, descending row (n-1-pos == ~pos for n = 2^HW)
    col_addr = {~pos, cw};
    last_pos = &pos;
    last_sym = &sym;
  end
endmodule

// File: rtl/rcs_pipe.sv
// Fixed-latency delay line standing in for the component decoder latency.
module rcs_pipe #(
  parameter int W = 8,
  parameter int D = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stg [D];

  for (genvar g = 0; g < D; g++) begin : g_stage
    logic [W-1:0] nxt;
    if (g == 0) begin : g_head
      assign nxt = din;
    end else begin : g_body
      assign nxt = stg[g-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg[g] <= '0;
      else        stg[g] <= nxt;
    end
  end

  assign dout = stg[D-1];
endmodule

// File: rtl/rcs_clash.sv
// Flags two reads or two writes on the same cell in one cycle.
module rcs_clash #(
  parameter int AW = 6
) (
  input  logic          a_rd_en,
  input  logic [AW-1:0] a_rd_addr,
  input  logic          b_rd_en,
  input  logic [AW-1:0] b_rd_addr,
  input  logic          a_wr_en,
  input  logic [AW-1:0] a_wr_addr,
  input  logic          b_wr_en,
  input  logic [AW-1:0] b_wr_addr,
  output logic          clash
);
  logic rd_hit;
  logic wr_hit;

  always_comb begin
    rd_hit = a_rd_en && b_rd_en && (a_rd_addr == b_rd_addr);
    wr_hit = a_wr_en && b_wr_en && (a_wr_addr == b_wr_addr);
    clash  = rd_hit || wr_hit;
  end
endmodule

// File: rtl/rcs_ctrl.sv
// Run/iteration sequencing: read phase, drain phase, completion pulse.
module rcs_ctrl
  import rcs_pkg::*;
#(
  parameter int HW  = 3,
  parameter int LAT = 8,
  parameter int KW  = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [KW-1:0]   iter_k,
  output logic            rd_en,
  output logic [2*HW-1:0] sym,
  output logic            busy,
  output logic            done,
  output logic [KW-1:0]   iter_num
);
  localparam int AW = 2 * HW;
  localparam int DW = $clog2(LAT + 1);
  localparam logic [AW-1:0] SYM_LAST   = {AW{1'b1}};
  localparam logic [DW-1:0] DRAIN_LAST = DW'(LAT - 1);

  rcs_state_e    st_q, st_d;
  logic [AW-1:0] sym_q, sym_d;
  logic [DW-1:0] dcnt_q, dcnt_d;
  logic [KW-1:0] itn_q, itn_d;
  logic [KW-1:0] k_q, k_d;
  logic          done_q, done_d;
  logic          cnt_ce;

  always_comb begin
    st_d   = st_q;
    sym_d  = sym_q;
    dcnt_d = dcnt_q;
    itn_d  = itn_q;
    k_d    = k_q;
    done_d = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (start) begin
          k_d    = iter_k;
          itn_d  = '0;
          sym_d  = '0;
          dcnt_d = '0;
          if (iter_k == '0) done_d = 1'b1;
          else              st_d   = ST_READ;
        end
      end
      ST_READ: begin
        sym_d = sym_q + 1'b1;
        if (sym_q == SYM_LAST) begin
          st_d   = ST_DRAIN;
          dcnt_d = '0;
        end
      end
      ST_DRAIN: begin
        dcnt_d = dcnt_q + 1'b1;
        if (dcnt_q == DRAIN_LAST) begin
          if (itn_q == k_q - 1'b1) begin
            st_d   = ST_IDLE;
            done_d = 1'b1;
          end else begin
            itn_d = itn_q + 1'b1;
            st_d  = ST_READ;
          end
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  // counters only move while a run is live or being launched
  assign cnt_ce = (st_q != ST_IDLE) || start;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      done_q <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sym_q  <= '0;
      dcnt_q <= '0;
      itn_q  <= '0;
      k_q    <= '0;
    end else if (cnt_ce) begin
      sym_q  <= sym_d;
      dcnt_q <= dcnt_d;
      itn_q  <= itn_d;
      k_q    <= k_d;
    end
  end

  assign rd_en    = (st_q == ST_READ);
  assign sym      = sym_q;
  assign busy     = (st_q != ST_IDLE);
  assign done     = done_q;
  assign iter_num = itn_q;
endmodule

// File: rtl/btc_rc_sched.sv
module btc_rc_sched #(
  parameter int HW  = 3,
  parameter int LAT = 8,
  parameter int KW  = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [KW-1:0]   iter_k,
  output logic            busy,
  output logic            done,
  output logic [KW-1:0]   iter_num,
  output logic            a_rd_en,
  output logic [2*HW-1:0] a_rd_addr,
  output logic            a_wr_en,
  output logic [2*HW-1:0] a_wr_addr,
  output logic            b_rd_en,
  output logic [2*HW-1:0] b_rd_addr,
  output logic            b_wr_en,
  output logic [2*HW-1:0] b_wr_addr,
  output logic            cw_done,
  output logic            iter_done,
  output logic            clash
);
  localparam int AW = 2 * HW;
  localparam int PW = 2 * AW + 3;

  // reset asserted asynchronously, released on the clock
  logic [1:0] rsync_q;
  logic       rst_s_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_s_n = rsync_q[1];

  logic          rd_en;
  logic [AW-1:0] sym;
  logic [AW-1:0] row_addr, col_addr;
  logic          last_pos, last_sym;
  logic [PW-1:0] pipe_in, pipe_out;
  logic          wr_en;
  logic [AW-1:0] wr_row, wr_col;
  logic          wr_last_pos, wr_last_sym;

  rcs_ctrl #(.HW(HW), .LAT(LAT), .KW(KW)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_s_n),
    .start    (start),
    .iter_k   (iter_k),
    .rd_en    (rd_en),
    .sym      (sym),
    .busy     (busy),
    .done     (done),
    .iter_num (iter_num)
  );

  rcs_addr_gen #(.HW(HW)) u_agen (
    .sym      (sym),
    .row_addr (row_addr),
    .col_addr (col_addr),
    .last_pos (last_pos),
    .last_sym (last_sym)
  );

  assign pipe_in = {rd_en, row_addr, col_addr, rd_en & last_pos, rd_en & last_sym};

  rcs_pipe #(.W(PW), .D(LAT)) u_wb (
    .clk   (clk),
    .rst_n (rst_s_n),
    .din   (pipe_in),
    .dout  (pipe_out)
  );

  assign {wr_en, wr_row, wr_col, wr_last_pos, wr_last_sym} = pipe_out;

  assign a_rd_en   = rd_en;
  assign a_rd_addr = row_addr;
  assign b_rd_en   = rd_en;
  assign b_rd_addr = col_addr;
  assign a_wr_en   = wr_en;
  assign a_wr_addr = wr_row;
  assign b_wr_en   = wr_en;
  assign b_wr_addr = wr_col;
  assign cw_done   = wr_last_pos;
  assign iter_done = wr_last_sym;

  rcs_clash #(.AW(AW)) u_clash (
    .a_rd_en   (a_rd_en),
    .a_rd_addr (a_rd_addr),
    .b_rd_en   (b_rd_en),
    .b_rd_addr (b_rd_addr),
    .a_wr_en   (a_wr_en),
    .a_wr_addr (a_wr_addr),
    .b_wr_en   (b_wr_en),
    .b_wr_addr (b_wr_addr),
    .clash     (clash)
  );
endmodule

// File: rtl/rcs_checker.sv
module rcs_checker #(
  parameter int HW = 3
) (
  input logic            clk,
  input logic            rst_n,
  input logic            busy,
  input logic            done,
  input logic            a_rd_en,
  input logic [2*HW-1:0] a_rd_addr,
  input logic            a_wr_en,
  input logic [2*HW-1:0] a_wr_addr,
  input logic            b_rd_en,
  input logic [2*HW-1:0] b_rd_addr,
  input logic            b_wr_en,
  input logic [2*HW-1:0] b_wr_addr,
  input logic            clash
);
  localparam int AW = 2 * HW;

  p_reads_apart_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (a_rd_en && b_rd_en) |-> (a_rd_addr != b_rd_addr));

  p_writes_apart_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (a_wr_en && b_wr_en) |-> (a_wr_addr != b_wr_addr));

  p_no_clash_r4: assert property (@(posedge clk) disable iff (!rst_n) !clash);

  p_col_mirror_r3: assert property (@(posedge clk) disable iff (!rst_n)
    a_rd_en |-> (b_rd_addr == {~a_rd_addr[HW-1:0], a_rd_addr[AW-1:HW]}));

  p_row_ascend_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (a_rd_en && $past(a_rd_en)) |-> (a_rd_addr == $past(a_rd_addr) + 1'b1));

  p_wb_in_run_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (a_wr_en || b_wr_en) |-> busy);

  p_done_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

bind btc_rc_sched rcs_checker #(.HW(HW)) u_rcs_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .busy      (busy),
  .done      (done),
  .a_rd_en   (a_rd_en),
  .a_rd_addr (a_rd_addr),
  .a_wr_en   (a_wr_en),
  .a_wr_addr (a_wr_addr),
  .b_rd_en   (b_rd_en),
  .b_rd_addr (b_rd_addr),
  .b_wr_en   (b_wr_en),
  .b_wr_addr (b_wr_addr),
  .clash     (clash)
);

// File: tb/btc_rc_sched_test.sv
module btc_rc_sched_test;
  localparam int HW     = 3;
  localparam int LAT    = 8;
  localparam int KW     = 4;
  localparam int AW     = 2 * HW;
  localparam int N      = 1 << HW;
  localparam int NSQ    = N * N;
  localparam int PER    = NSQ + LAT;
  localparam int CLK_NS = 10;

  logic          clk, rst_n, start;
  logic [KW-1:0] iter_k;
  logic          busy, done, a_rd_en, a_wr_en, b_rd_en, b_wr_en;
  logic          cw_done, iter_done, clash;
  logic [KW-1:0] iter_num;
  logic [AW-1:0] a_rd_addr, a_wr_addr, b_rd_addr, b_wr_addr;

  int n_chk  = 0;
  int n_fail = 0;

  btc_rc_sched #(.HW(HW), .LAT(LAT), .KW(KW)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .iter_k(iter_k),
    .busy(busy), .done(done), .iter_num(iter_num),
    .a_rd_en(a_rd_en), .a_rd_addr(a_rd_addr), .a_wr_en(a_wr_en), .a_wr_addr(a_wr_addr),
    .b_rd_en(b_rd_en), .b_rd_addr(b_rd_addr), .b_wr_en(b_wr_en), .b_wr_addr(b_wr_addr),
    .cw_done(cw_done), .iter_done(iter_done), .clash(clash)
  );

  initial clk = 1'b0;
  always #(CLK_NS/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // expected row-port address of linear index s: row s/n, column s%n
  function automatic int row_of(input int s);
    return ((s / N) << HW) | (s % N);
  endfunction
  // expected column-port address: row n-1-(s%n), column s/n
  function automatic int col_of(input int s);
    return ((N - 1 - (s % N)) << HW) | (s / N);
  endfunction

  // checks one sampled cycle t of a run of k iterations
  task automatic check_cycle(input int t, input int k);
    int  u, it, v;
    bit  live, e_rd, e_wr;
    live = t < k * PER;
    u    = t % PER;
    it   = t / PER;
    e_rd = live && (u < NSQ);
    e_wr = live && (u >= LAT);
    v    = u - LAT;
    chk(busy == live, "R7 busy", busy, live);
    chk(done == (t == k * PER), "R7 done", done, t == k * PER);
    chk(a_rd_en == e_rd && b_rd_en == e_rd, "R6 read enables", {a_rd_en, b_rd_en}, {e_rd, e_rd});
    if (e_rd) begin
      chk(a_rd_addr == AW'(row_of(u)), "R2 row read addr", a_rd_addr, row_of(u));
      chk(b_rd_addr == AW'(col_of(u)), "R3 col read addr", b_rd_addr, col_of(u));
    end
    chk(a_wr_en == e_wr && b_wr_en == e_wr, "R5 write enables", {a_wr_en, b_wr_en}, {e_wr, e_wr});
    if (e_wr) begin
      chk(a_wr_addr == AW'(row_of(v)), "R5 row write addr", a_wr_addr, row_of(v));
      chk(b_wr_addr == AW'(col_of(v)), "R5 col write addr", b_wr_addr, col_of(v));
      chk(cw_done == ((v % N) == N - 1), "R8 cw_done", cw_done, (v % N) == N - 1);
      chk(iter_done == (v == NSQ - 1), "R8 iter_done", iter_done, v == NSQ - 1);
    end else begin
      chk(!cw_done && !iter_done, "R8 flags idle", {cw_done, iter_done}, 0);
    end
    if (live) chk(iter_num == KW'(it), "R8 iter_num", iter_num, it);
    chk(!clash, "R4 clash", clash, 0);
  endtask

  // one run; a start is re-pulsed at cycle poke (if >=0) with another count
  task automatic run(input int k, input int poke);
    @(negedge clk);
    start  = 1'b1;
    iter_k = KW'(k);
    @(negedge clk);
    start = 1'b0;
    for (int t = 0; t <= k * PER + 1; t++) begin
      if (t > 0) @(negedge clk);
      if (t == poke) begin
        start  = 1'b1;
        iter_k = KW'(k + 2);
      end else begin
        start = 1'b0;
      end
      check_cycle(t, k);
    end
    start = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    int seed;
    seed   = 7;
    void'($urandom(seed));
    rst_n  = 1'b0;
    start  = 1'b0;
    iter_k = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(!busy && !done && !clash, "R1 status in reset", {busy, done, clash}, 0);
    chk(!a_rd_en && !b_rd_en && !a_wr_en && !b_wr_en, "R1 enables in reset",
        {a_rd_en, b_rd_en, a_wr_en, b_wr_en}, 0);
    chk(!cw_done && !iter_done, "R1 flags in reset", {cw_done, iter_done}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!busy && !done && !a_rd_en && !a_wr_en, "R1 idle after reset",
        {busy, done, a_rd_en, a_wr_en}, 0);
    // R10: zero iterations
    run(0, -1);
    // directed: single iteration, then two with R9 start pokes mid-read and mid-drain
    run(1, -1);
    run(2, 5);
    run(2, NSQ + 3);
    // random iteration counts and poke points
    for (int r = 0; r < 5; r++) begin
      int k, p;
      k = 1 + int'($urandom_range(2));
      p = int'($urandom_range(k * PER - 1));
      run(k, p);
    end
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(CLK_NS * 100000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule